// File: doc/BRIEF.md
# Two-Press Switch Word Capture Peripheral

This block is a memory-mapped peripheral on an AXI4-Lite slave port. It assembles a 32-bit word from two successive samples of a 16-bit bank of slide switches. Each sample is taken when an operator presses one push button and then lets it go. The first completed press fills the low half of the word. The second completed press fills the high half. After the second press a ready flag is raised.

A processor can learn that the word is complete in two ways. It can poll a status register, or it can enable a level interrupt. It then reads the word and writes a one to the status register to clear the flag. While the flag is set, further button activity is dropped, so an unread word is never overwritten. The button input is asynchronous and mechanically noisy. It passes through a two-stage synchroniser and a counter debouncer. A sample is taken only on the debounced falling (release) edge.

Register layout, with byte offsets decoded from address bits [3:2]:
- 0x0 CAPWORD reads the assembled word.
- 0x4 CAPSTAT reads bit 0 = ready and bit 1 = next sample goes to the high half. Writing a one to bit 0 clears ready.
- 0x8 CAPCTRL bit 0 is the interrupt enable.

Top module: `swcap_axil`

## Requirements
- R1: After synchronous active-low reset, CAPWORD reads 0, CAPSTAT reads 0, CAPCTRL reads 0 and irq_o is 0.
- R2: A button pulse whose synchronised level lasts fewer than DEBOUNCE_CYCLES consecutive cycles is rejected. No sample is taken and CAPSTAT stays unchanged.
- R3: Holding the button pressed takes no sample. The sample is taken only after the debounced level returns from pressed (1) to released (0).
- R4: When CAPSTAT bit 1 is 0, a completed press stores sw_i into CAPWORD bits [15:0] and leaves bits [31:16] unchanged. CAPSTAT bit 1 then becomes 1.
- R5: When CAPSTAT bit 1 is 1, a completed press stores sw_i into CAPWORD bits [31:16]. CAPSTAT bit 0 (ready) then becomes 1 and bit 1 returns to 0.
- R6: While ready is 1, completed presses are ignored: CAPWORD and CAPSTAT stay unchanged.
- R7: A write to offset 0x4 with wdata bit 0 = 1 (and wstrb bit 0 = 1) clears ready. A write there with bit 0 = 0 has no effect.
- R8: irq_o is a level equal to ready AND CAPCTRL bit 0, checked on every clock.
- R9: Every write and read response is OKAY (2'b00). A write to offset 0x0 is ignored. A read of offset 0xC returns 0.
- R10: After ready is cleared, the next completed press again fills bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 1 | Asynchronous push button, 1 = pressed |
| sw_i | input | SW_W | Slide switch bank |
| irq_o | output | 1 | Level interrupt: ready AND enable |
| s_axi_awaddr | input | ADDR_W | Write address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_wdata | input | 2*SW_W | Write data |
| s_axi_wstrb | input | SW_W/4 | Write byte strobes |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_bresp | output | 2 | Write response |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_araddr | input | ADDR_W | Read address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_rdata | output | 2*SW_W | Read data |
| s_axi_rresp | output | 2 | Read response |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data ready |

## Verification
The assertions check on every cycle that:
- the word is frozen while ready is set;
- ready rises only out of the high-half capture and leaves the half pointer on the low half;
- a clear request removes ready;
- the interrupt never asserts without ready;
- write and read responses hold until accepted.

Debounce rejection of short pulses, the rule that only a release takes a sample, and the exact switch values landing in each half can only be shown by the bench's button scenarios and register reads. Its behavioural model tracks the interrupt level and both response valids cycle by cycle.

// File: rtl/swcap_pkg.sv
// Package: shared register indices and response codes for the switch
// word capture peripheral. Indices are word offsets (address bits [3:2]).
package swcap_pkg;
    localparam logic [1:0] IDX_WORD  = 2'd0;
    localparam logic [1:0] IDX_STAT  = 2'd1;
    localparam logic [1:0] IDX_CTRL  = 2'd2;
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/swcap_btn_cond.sv
// Module: swcap_btn_cond
// Brings an asynchronous push button into the clock domain with two flops,
// filters it with a counter debouncer and emits a one-cycle pulse when the
// debounced level goes from pressed (1) to released (0).
// Assumes: DEBOUNCE_CYCLES >= 2; synchronous active-low reset.
module swcap_btn_cond #(
    parameter int DEBOUNCE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic release_o
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    logic          sync1_q, sync2_q;
    logic          level_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchroniser for the raw button.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= btn_i;
            sync2_q <= sync1_q;
        end
    end

    // Accept a new level after it persists; pulse on accepted release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= 1'b0;
            cnt_q     <= '0;
            release_o <= 1'b0;
        end else if (sync2_q != level_q) begin
            if (cnt_q == LAST) begin
                level_q   <= sync2_q;
                cnt_q     <= '0;
                release_o <= level_q;
            end else begin
                cnt_q     <= cnt_q + 1'b1;
                release_o <= 1'b0;
            end
        end else begin
            cnt_q     <= '0;
            release_o <= 1'b0;
        end
    end
endmodule

// File: rtl/swcap_seq.sv
// Module: swcap_seq
// Two-phase capture sequencer: each release pulse stores the switch bank
// into the half selected by the pointer; the high-half store sets ready.
// Pulses are dropped while ready is set. Assumes clear_i is a one-cycle pulse.
module swcap_seq #(
    parameter int SW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              release_i,
    input  logic [SW_W-1:0]   sw_i,
    input  logic              clear_i,
    output logic [2*SW_W-1:0] word_o,
    output logic              ready_o,
    output logic              upper_o
);
    logic [1:0][SW_W-1:0] half_q;
    logic                 take;

    assign take = release_i & ~ready_o;

    // One capture register per half, enabled by the pointer.
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_q[h] <= '0;
            else if (take && (upper_o == 1'(h)))
                half_q[h] <= sw_i;
        end
    end

    // Half pointer and ready flag; a completed word wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_o <= 1'b0;
            ready_o <= 1'b0;
        end else begin
            if (take)
                upper_o <= ~upper_o;
            if (take && upper_o)
                ready_o <= 1'b1;
            else if (clear_i)
                ready_o <= 1'b0;
        end
    end

    assign word_o = {half_q[1], half_q[0]};
endmodule

// File: rtl/swcap_regs.sv
// Module: swcap_regs
// AXI4-Lite register file. A write is taken when address and data are both
// valid and no response is pending; a read when no read data is pending.
// Decodes address bits [3:2] only; all responses are OKAY.
// Assumes ADDR_W >= 4 and DATA_W >= 2.
module swcap_regs
    import swcap_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] word_i,
    input  logic              ready_i,
    input  logic              upper_i,
    output logic              clear_o,
    output logic              ien_o
);
    logic              wr_go, rd_go;
    logic [1:0]        wr_idx, rd_idx;
    logic [DATA_W-1:0] rd_mux;

    assign wr_go   = awvalid & wvalid & ~bvalid;
    assign rd_go   = arvalid & ~rvalid;
    assign wr_idx  = awaddr[3:2];
    assign rd_idx  = araddr[3:2];
    assign awready = ~bvalid;
    assign wready  = ~bvalid;
    assign arready = ~rvalid;
    assign bresp   = RESP_OKAY;
    assign rresp   = RESP_OKAY;
    assign clear_o = wr_go & (wr_idx == IDX_STAT) & wstrb[0] & wdata[0];

    // Read data selection by word index.
    always_comb begin
        rd_mux = '0;
        case (rd_idx)
            IDX_WORD: rd_mux = word_i;
            IDX_STAT: rd_mux[1:0] = {upper_i, ready_i};
            IDX_CTRL: rd_mux[0] = ien_o;
            default:  rd_mux = '0;
        endcase
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_o <= 1'b0;
        else if (wr_go && wr_idx == IDX_CTRL && wstrb[0])
            ien_o <= wdata[0];
    end

    // Write response channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bvalid <= 1'b0;
        else if (wr_go)
            bvalid <= 1'b1;
        else if (bready)
            bvalid <= 1'b0;
    end

    // Read data channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_mux;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/swcap_axil.sv
// Module: swcap_axil (top)
// Switch word capture peripheral: button conditioner, two-phase sequencer
// and AXI4-Lite register file; irq_o is ready gated by the enable bit.
// Assumes SW_W is a multiple of 4 so the word width is whole bytes.
module swcap_axil #(
    parameter int SW_W            = 16,
    parameter int ADDR_W          = 4,
    parameter int DEBOUNCE_CYCLES = 1_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 btn_i,
    input  logic [SW_W-1:0]      sw_i,
    output logic                 irq_o,
    input  logic [ADDR_W-1:0]    s_axi_awaddr,
    input  logic                 s_axi_awvalid,
    output logic                 s_axi_awready,
    input  logic [2*SW_W-1:0]    s_axi_wdata,
    input  logic [SW_W/4-1:0]    s_axi_wstrb,
    input  logic                 s_axi_wvalid,
    output logic                 s_axi_wready,
    output logic [1:0]           s_axi_bresp,
    output logic                 s_axi_bvalid,
    input  logic                 s_axi_bready,
    input  logic [ADDR_W-1:0]    s_axi_araddr,
    input  logic                 s_axi_arvalid,
    output logic                 s_axi_arready,
    output logic [2*SW_W-1:0]    s_axi_rdata,
    output logic [1:0]           s_axi_rresp,
    output logic                 s_axi_rvalid,
    input  logic                 s_axi_rready
);
    localparam int DATA_W = 2 * SW_W;

    logic              rel_pulse;
    logic              clr_pulse;
    logic              seq_ready, seq_upper, ctrl_ien;
    logic [DATA_W-1:0] seq_word;

    swcap_btn_cond #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_btn (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .release_o(rel_pulse)
    );

    swcap_seq #(.SW_W(SW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .release_i(rel_pulse), .sw_i(sw_i),
        .clear_i(clr_pulse), .word_o(seq_word), .ready_o(seq_ready),
        .upper_o(seq_upper)
    );

    swcap_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_axi_awaddr), .awvalid(s_axi_awvalid), .awready(s_axi_awready),
        .wdata(s_axi_wdata), .wstrb(s_axi_wstrb), .wvalid(s_axi_wvalid),
        .wready(s_axi_wready), .bresp(s_axi_bresp), .bvalid(s_axi_bvalid),
        .bready(s_axi_bready), .araddr(s_axi_araddr), .arvalid(s_axi_arvalid),
        .arready(s_axi_arready), .rdata(s_axi_rdata), .rresp(s_axi_rresp),
        .rvalid(s_axi_rvalid), .rready(s_axi_rready),
        .word_i(seq_word), .ready_i(seq_ready), .upper_i(seq_upper),
        .clear_o(clr_pulse), .ien_o(ctrl_ien)
    );

    assign irq_o = seq_ready & ctrl_ien;
endmodule

// File: rtl/swcap_axil_chk.sv
// Module: swcap_axil_chk
// Property checker bound into swcap_axil; observes sequencer state, the
// clear pulse from the register file, the interrupt and AXI handshakes.
module swcap_axil_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              upper,
    input logic              clear,
    input logic [DATA_W-1:0] word,
    input logic              irq,
    input logic              bvalid,
    input logic              bready,
    input logic              rvalid,
    input logic              rready
);
    p_word_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(word));

    p_ready_from_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(upper) && !upper));

    p_clear_drops_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clear) |=> !ready);

    p_irq_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);

    p_bresp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> rvalid);
endmodule

bind swcap_axil swcap_axil_chk #(.DATA_W(2 * SW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(seq_ready), .upper(seq_upper),
    .clear(clr_pulse), .word(seq_word), .irq(irq_o),
    .bvalid(s_axi_bvalid), .bready(s_axi_bready),
    .rvalid(s_axi_rvalid), .rready(s_axi_rready)
);

// File: tb/sim_swcap_axil.sv
// Bench: drives the button, switches and AXI4-Lite master; a behavioural
// model tracks the interrupt and response valids on every clock.
module sim_swcap_axil;
    localparam int DEB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn = 1'b0;
    logic [15:0] sw = '0;
    logic        irq;
    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = 4'hF;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    swcap_axil #(.SW_W(16), .ADDR_W(4), .DEBOUNCE_CYCLES(DEB)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .sw_i(sw), .irq_o(irq),
        .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
        .s_axi_wdata(wdata), .s_axi_wstrb(wstrb), .s_axi_wvalid(wvalid),
        .s_axi_wready(wready), .s_axi_bresp(bresp), .s_axi_bvalid(bvalid),
        .s_axi_bready(1'b1), .s_axi_araddr(araddr), .s_axi_arvalid(arvalid),
        .s_axi_arready(arready), .s_axi_rdata(rdata), .s_axi_rresp(rresp),
        .s_axi_rvalid(rvalid), .s_axi_rready(1'b1)
    );

    // Behavioural model state.
    logic        m_s1, m_s2, m_lvl, m_rel, m_ready, m_upper, m_ien, m_bv, m_rv;
    int          m_cnt;
    logic [31:0] m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_rel <= 0; m_cnt <= 0;
            m_ready <= 0; m_upper <= 0; m_ien <= 0; m_bv <= 0; m_rv <= 0;
            m_word <= '0;
        end else begin
            m_s1 <= btn;
            m_s2 <= m_s1;
            m_rel <= 0;
            if (m_s2 == m_lvl) m_cnt <= 0;
            else if (m_cnt == DEB - 1) begin
                m_lvl <= m_s2; m_cnt <= 0; m_rel <= m_lvl;
            end else m_cnt <= m_cnt + 1;
            if (awvalid && wvalid && !m_bv) begin
                m_bv <= 1;
                if (awaddr[3:2] == 2'd1 && wdata[0]) m_ready <= 0;
                if (awaddr[3:2] == 2'd2) m_ien <= wdata[0];
            end else m_bv <= 0;
            m_rv <= arvalid && !m_rv;
            if (m_rel && !m_ready) begin
                if (!m_upper) begin m_word[15:0] <= sw; m_upper <= 1; end
                else begin m_word[31:16] <= sw; m_upper <= 0; m_ready <= 1; end
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq !== (m_ready & m_ien)) begin
                errors++;
                $display("FAIL R8 irq_o act=%b exp=%b at %0t", irq, m_ready & m_ien, $time);
            end
            checks++;
            if (bvalid !== m_bv || rvalid !== m_rv) begin
                errors++;
                $display("FAIL R9 bvalid/rvalid act=%b%b exp=%b%b", bvalid, rvalid, m_bv, m_rv);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check("R9 bresp", {30'b0, bresp}, 32'h0);
        @(negedge clk);
    endtask

    task automatic axi_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        d = rdata;
        check("R9 rresp", {30'b0, rresp}, 32'h0);
        @(negedge clk);
    endtask

    task automatic press(input logic [15:0] val, input int hold);
        @(negedge clk);
        sw = val; btn = 1;
        repeat (hold) @(negedge clk);
        btn = 0;
        repeat (DEB + 8) @(negedge clk);
    endtask

    logic [31:0] rv;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        axi_rd(4'h0, rv); check("R1 word after reset", rv, 32'h0);
        axi_rd(4'h4, rv); check("R1 status after reset", rv, 32'h0);
        axi_rd(4'h8, rv); check("R1 ctrl after reset", rv, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        press(16'h1111, 5);
        axi_rd(4'h4, rv); check("R2 short pulse rejected", rv, 32'h0);
        axi_rd(4'h0, rv); check("R2 word after short pulse", rv, 32'h0);

        @(negedge clk); sw = 16'hF00D; btn = 1;
        repeat (DEB + 10) @(negedge clk);
        axi_rd(4'h4, rv); check("R3 no capture while held", rv, 32'h0);
        btn = 0;
        repeat (DEB + 8) @(negedge clk);
        axi_rd(4'h4, rv); check("R3 capture after release", rv, 32'h2);
        axi_rd(4'h0, rv); check("R4 low half", rv, 32'h0000F00D);

        axi_wr(4'h8, 32'h1);
        axi_rd(4'h8, rv); check("R8 ctrl enable", rv, 32'h1);
        press(16'hBAAD, 30);
        axi_rd(4'h0, rv); check("R5 high half", rv, 32'hBAADF00D);
        axi_rd(4'h4, rv); check("R5 ready set", rv, 32'h1);
        check("R8 irq raised", {31'b0, irq}, 32'h1);

        press(16'h1234, 30);
        axi_rd(4'h0, rv); check("R6 word kept while ready", rv, 32'hBAADF00D);
        axi_rd(4'h4, rv); check("R6 status kept while ready", rv, 32'h1);

        axi_wr(4'h4, 32'h0);
        axi_rd(4'h4, rv); check("R7 write zero no effect", rv, 32'h1);
        axi_wr(4'h0, 32'hFFFFFFFF);
        axi_rd(4'h0, rv); check("R9 word write ignored", rv, 32'hBAADF00D);
        axi_rd(4'hC, rv); check("R9 unmapped read zero", rv, 32'h0);
        axi_wr(4'h4, 32'h1);
        axi_rd(4'h4, rv); check("R7 ready cleared", rv, 32'h0);
        check("R8 irq dropped", {31'b0, irq}, 32'h0);

        press(16'h5555, 30);
        axi_rd(4'h0, rv); check("R10 restart low half", rv, 32'hBAAD5555);
        axi_rd(4'h4, rv); check("R10 pointer upper", rv, 32'h2);

        axi_wr(4'h8, 32'h0);
        press(16'hAAAA, 30);
        axi_rd(4'h0, rv); check("R5 second word", rv, 32'hAAAA5555);
        axi_rd(4'h4, rv); check("R5 ready again", rv, 32'h1);
        check("R8 irq masked", {31'b0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule